// File: doc/BRIEF.md
# Oscillator Sensor Array Scan Sequencer

This block runs a measurement sweep over a grid of ring-oscillator temperature sensors, 4 rows by 6 columns. It powers one sensor at a time and opens a counting window of fixed length for it. When an external counter reports the result, the block latches the count, drops every enable for one cycle and moves to the next sensor. Measuring in strict rotation keeps self-heating low, because no two oscillators ever run together.

When all 24 counts are held, the block sends them to a host over a byte stream with a valid/ready handshake. The counts travel through a shift-register scan path. Each sweep leaves as one framed burst. In continuous mode the next sweep starts as soon as the frame is fully sent. Otherwise the block waits for a trigger pulse. The window length is a parameter, so the sweep time can be matched to the refresh rate the system needs.

Top module: `sensor_scan_top`

## Requirements
- R1: While reset is asserted, every sensor enable is low and `meas_start_o` and `tx_valid_o` are low.
- R2: At most one enable bit is high in any cycle. Sensor k = row*6 + col is enabled on bit k, and sweeps visit k = 0, 1, ..., 23 in order.
- R3: Between two consecutive sensors of one sweep, all enables are low for exactly one cycle.
- R4: `meas_start_o` rises together with a sensor's enable and stays high for exactly WIN_CYC cycles. `meas_done_i` is ignored while it is high. The count is latched in the first cycle after the window in which `meas_done_i` is high.
- R5: A frame is 121 bytes. It starts with the header 0xA5. Then, for each sensor k in order, it carries the byte k followed by the count zero-extended to 32 bits, most significant byte first. The first of these count bytes is {6'b0, count[25:24]}.
- R6: A byte is taken only in a cycle where `tx_valid_o` and `tx_ready_i` are both high. While valid is high and ready is low, valid stays high and `tx_data_o` does not change.
- R7: No sensor enable is high while `tx_valid_o` is high.
- R8: With `cont_mode_i` high, sensor 0 is enabled in the cycle right after the last byte of a frame is taken.
- R9: With `cont_mode_i` low, the block stays idle after a frame, with no enable and no valid. A `trigger_i` pulse while idle enables sensor 0 in the next cycle. A trigger pulse during a sweep starts no extra sweep.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cont_mode_i | input | 1 | High: sweeps repeat back to back |
| trigger_i | input | 1 | One-cycle request for a sweep when idle |
| sens_en_o | output | 24 | One-hot sensor enable, bit k for sensor k |
| meas_start_o | output | 1 | Counting window gate to the counter |
| meas_done_i | input | 1 | Counter result is valid |
| meas_count_i | input | 26 | Counter result |
| tx_data_o | output | 8 | Frame byte |
| tx_valid_o | output | 1 | Frame byte available |
| tx_ready_i | input | 1 | Host accepts the byte |

## Verification
The hardest case to reach is a long stall on the byte stream at the same time as the scan path steps between sensors. That is when data could be lost or repeated. The bench drives ready from a biased random source and adds one directed stretch of 30 cycles with ready held low in the middle of a frame. Each received byte is compared with a frame rebuilt from the counts the bench itself fed in. The counter model also raises done early, with junk values, inside the window. It then answers after a random delay, and the first sweep uses the all-ones and zero counts at the two ends of the grid.

// File: rtl/sensor_scan_pkg.sv
package sensor_scan_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_GATE,
    ST_WAIT,
    ST_GAP,
    ST_TX
  } seq_state_e;

  localparam int unsigned WORD_W = 32;
endpackage

// File: rtl/scan_seq.sv
module scan_seq
  import sensor_scan_pkg::*;
#(
  parameter int unsigned N_SENS  = 24,
  parameter int unsigned WIN_CYC = 16,
  localparam int unsigned IDX_W  = $clog2(N_SENS),
  localparam int unsigned WIN_W  = $clog2(WIN_CYC + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cont_mode_i,
  input  logic              trigger_i,
  input  logic              meas_done_i,
  input  logic              frame_done_i,
  output logic [N_SENS-1:0] sens_en_o,
  output logic              meas_start_o,
  output logic              capture_o,
  output logic              tx_start_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SENS - 1);
  localparam logic [WIN_W-1:0] WIN_END  = WIN_W'(WIN_CYC - 1);

  seq_state_e       state_q;
  logic [IDX_W-1:0] idx_q;
  logic [WIN_W-1:0] win_q;
  logic             sens_on;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      idx_q   <= '0;
      win_q   <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (cont_mode_i || trigger_i) begin
          state_q <= ST_GATE;
          idx_q   <= '0;
          win_q   <= '0;
        end
        ST_GATE: begin
          if (win_q == WIN_END) state_q <= ST_WAIT;
          else                  win_q   <= win_q + 1'b1;
        end
        ST_WAIT: if (meas_done_i) state_q <= ST_GAP;
        ST_GAP: begin
          if (idx_q == LAST_IDX) begin
            state_q <= ST_TX;
          end else begin
            idx_q   <= idx_q + 1'b1;
            win_q   <= '0;
            state_q <= ST_GATE;
          end
        end
        ST_TX: if (frame_done_i) begin
          // back-to-back restart skips the idle state
          if (cont_mode_i) begin
            state_q <= ST_GATE;
            idx_q   <= '0;
            win_q   <= '0;
          end else begin
            state_q <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign sens_on      = (state_q == ST_GATE) || (state_q == ST_WAIT);
  assign meas_start_o = (state_q == ST_GATE);
  assign capture_o    = (state_q == ST_WAIT) && meas_done_i;
  assign tx_start_o   = (state_q == ST_GAP) && (idx_q == LAST_IDX);

  for (genvar k = 0; k < N_SENS; k++) begin : g_en
    assign sens_en_o[k] = sens_on && (idx_q == IDX_W'(k));
  end

  p_onehot_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(sens_en_o));

  p_gap_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((|sens_en_o) && (sens_en_o != $past(sens_en_o))) |-> ($past(sens_en_o) == '0));

  p_gate_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    meas_start_o |-> (|sens_en_o));

  p_capture_after_gate_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    capture_o |=> ((sens_en_o == '0) && !meas_start_o));
endmodule

// File: rtl/scan_chain.sv
module scan_chain #(
  parameter int unsigned N_STAGE = 24,
  parameter int unsigned DATA_W  = 26
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic              adv_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [DATA_W-1:0] head_o
);
  logic [DATA_W-1:0] stg_q [N_STAGE];

  // captures enter at the tail; transmit drains from the head
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < N_STAGE; k++) stg_q[k] <= '0;
    end else if (load_i || adv_i) begin
      for (int k = 0; k < N_STAGE - 1; k++) stg_q[k] <= stg_q[k+1];
      stg_q[N_STAGE-1] <= load_i ? data_i : '0;
    end
  end

  assign head_o = stg_q[0];

  p_single_shift_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(load_i && adv_i));
endmodule

// File: rtl/frame_tx.sv
module frame_tx
  import sensor_scan_pkg::*;
#(
  parameter int unsigned N_SENS   = 24,
  parameter int unsigned CNT_W    = 26,
  parameter logic [7:0]  HDR_BYTE = 8'hA5,
  localparam int unsigned IDX_W   = $clog2(N_SENS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [CNT_W-1:0] head_i,
  input  logic             tx_ready_i,
  output logic [7:0]       tx_data_o,
  output logic             tx_valid_o,
  output logic             adv_o,
  output logic             done_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_SENS - 1);

  logic             active_q, hdr_q;
  logic [IDX_W-1:0] sens_q;
  logic [2:0]       bsel_q;
  logic             acc;
  logic [WORD_W-1:0] word;

  assign acc    = active_q && tx_ready_i;
  assign adv_o  = acc && !hdr_q && (bsel_q == 3'd4);
  assign done_o = adv_o && (sens_q == LAST_IDX);
  assign word   = WORD_W'(head_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      hdr_q    <= 1'b0;
      sens_q   <= '0;
      bsel_q   <= '0;
    end else if (start_i) begin
      active_q <= 1'b1;
      hdr_q    <= 1'b1;
      sens_q   <= '0;
      bsel_q   <= '0;
    end else if (acc) begin
      if (hdr_q) begin
        hdr_q <= 1'b0;
      end else if (bsel_q == 3'd4) begin
        bsel_q <= '0;
        if (sens_q == LAST_IDX) active_q <= 1'b0;
        else                    sens_q   <= sens_q + 1'b1;
      end else begin
        bsel_q <= bsel_q + 1'b1;
      end
    end
  end

  always_comb begin
    if (hdr_q) begin
      tx_data_o = HDR_BYTE;
    end else begin
      case (bsel_q)
        3'd0:    tx_data_o = 8'(sens_q);
        3'd1:    tx_data_o = word[31:24];
        3'd2:    tx_data_o = word[23:16];
        3'd3:    tx_data_o = word[15:8];
        default: tx_data_o = word[7:0];
      endcase
    end
  end

  assign tx_valid_o = active_q;

  p_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_valid_o && !tx_ready_i) |=> (tx_valid_o && $stable(tx_data_o)));

  p_start_idle_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> !tx_valid_o);
endmodule

// File: rtl/sensor_scan_top.sv
module sensor_scan_top #(
  parameter int unsigned N_ROWS   = 4,
  parameter int unsigned N_COLS   = 6,
  parameter int unsigned CNT_W    = 26,
  parameter int unsigned WIN_CYC  = 16,
  parameter logic [7:0]  HDR_BYTE = 8'hA5,
  localparam int unsigned N_SENS  = N_ROWS * N_COLS
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cont_mode_i,
  input  logic              trigger_i,
  output logic [N_SENS-1:0] sens_en_o,
  output logic              meas_start_o,
  input  logic              meas_done_i,
  input  logic [CNT_W-1:0]  meas_count_i,
  output logic [7:0]        tx_data_o,
  output logic              tx_valid_o,
  input  logic              tx_ready_i
);
  logic capture, tx_start, adv, frame_done;
  logic [CNT_W-1:0] head;

  scan_seq #(.N_SENS(N_SENS), .WIN_CYC(WIN_CYC)) u_seq (
    .clk_i, .rst_ni, .cont_mode_i, .trigger_i, .meas_done_i,
    .frame_done_i(frame_done), .sens_en_o, .meas_start_o,
    .capture_o(capture), .tx_start_o(tx_start)
  );

  scan_chain #(.N_STAGE(N_SENS), .DATA_W(CNT_W)) u_chain (
    .clk_i, .rst_ni, .load_i(capture), .adv_i(adv),
    .data_i(meas_count_i), .head_o(head)
  );

  frame_tx #(.N_SENS(N_SENS), .CNT_W(CNT_W), .HDR_BYTE(HDR_BYTE)) u_tx (
    .clk_i, .rst_ni, .start_i(tx_start), .head_i(head), .tx_ready_i,
    .tx_data_o, .tx_valid_o, .adv_o(adv), .done_o(frame_done)
  );

  p_quiet_tx_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o |-> (sens_en_o == '0));
endmodule

// File: tb/sensor_scan_top_tb_top.sv
module sensor_scan_top_tb_top;
  localparam int WIN = 12;
  localparam int NS  = 24;

  logic clk = 1'b0, rst_n = 1'b0, cont = 1'b1, trig = 1'b0;
  logic done = 1'b0, ready = 1'b0;
  logic [25:0] cnt = '0;
  logic [NS-1:0] en;
  logic start, tx_valid;
  logic [7:0] tx_data;

  sensor_scan_top #(.WIN_CYC(WIN)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .cont_mode_i(cont), .trigger_i(trig),
    .sens_en_o(en), .meas_start_o(start), .meas_done_i(done),
    .meas_count_i(cnt), .tx_data_o(tx_data), .tx_valid_o(tx_valid),
    .tx_ready_i(ready)
  );

  always #5 clk = ~clk;

  int checks = 0, fails = 0;
  int ready_pct = 100;
  logic [25:0] exp_cnt [NS];
  logic [NS-1:0] prev_en = '0;
  logic prev_start = 0, prev_valid = 0, prev_ready = 0, last_acc = 0;
  logic [7:0] prev_data = '0;
  int start_len = 0, gap_cnt = 0, next_idx = 0, cur_idx = 0;
  int resp_wait = -1, pos = 0, frames = 0;

  task automatic chk(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_byte(int p);
    int k, j;
    logic [31:0] w;
    if (p == 0) return 8'hA5;
    k = (p - 1) / 5;
    j = (p - 1) % 5;
    w = {6'b0, exp_cnt[k]};
    case (j)
      0: return 8'(k);
      1: return w[31:24];
      2: return w[23:16];
      3: return w[15:8];
      default: return w[7:0];
    endcase
  endfunction

  // monitor, counter model and byte sink
  always @(negedge clk) begin
    if (rst_n) begin
      logic [25:0] v;
      done = 1'b0;
      chk($onehot0(en), "R2", 32'(en), 0);
      if (last_acc) begin
        if (cont) chk(en == 24'd1, "R8", 32'(en), 1);
        else      chk(en == '0 && !tx_valid, "R9", 32'(en), 0);
        last_acc = 0;
      end
      if (en != '0 && en != prev_en) begin
        chk(prev_en == '0, "R3", 32'(prev_en), 0);
        chk(en == (24'd1 << next_idx), "R2", 32'(en), 32'(24'd1 << next_idx));
        if (next_idx != 0) chk(gap_cnt == 1, "R3", gap_cnt, 1);
        cur_idx  = next_idx;
        next_idx = (next_idx + 1) % NS;
      end
      gap_cnt = (en == '0) ? gap_cnt + 1 : 0;
      if (start) begin
        chk(en != '0, "R4", 32'(en), 1);
        start_len++;
        if ($urandom % 4 == 0) begin
          done = 1'b1;
          cnt  = 26'($urandom);
        end
      end
      if (prev_start && !start) begin
        chk(start_len == WIN, "R4", start_len, WIN);
        start_len = 0;
        resp_wait = int'($urandom % 4);
      end
      if (!start && resp_wait >= 0) begin
        if (resp_wait == 0) begin
          v = 26'($urandom);
          if (frames == 0 && cur_idx == 0)  v = 26'h3FFFFFF;
          if (frames == 0 && cur_idx == 23) v = 26'h0;
          exp_cnt[cur_idx] = v;
          cnt  = v;
          done = 1'b1;
          resp_wait = -1;
        end else begin
          resp_wait--;
        end
      end
      if (tx_valid) chk(en == '0, "R7", 32'(en), 0);
      if (prev_valid && !prev_ready)
        chk(tx_valid && tx_data == prev_data, "R6", 32'(tx_data), 32'(prev_data));
      ready = (int'($urandom % 100) < ready_pct);
      if (tx_valid && ready) begin
        chk(tx_data == exp_byte(pos), "R5", 32'(tx_data), 32'(exp_byte(pos)));
        pos++;
        if (pos == 1 + NS * 5) begin
          pos = 0;
          frames++;
          last_acc = 1;
        end
      end
      prev_valid = tx_valid;
      prev_ready = ready;
      prev_data  = tx_data;
      prev_en    = en;
      prev_start = start;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", frames, 5);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    chk(en == '0 && !start && !tx_valid, "R1", 32'(en), 0);
    rst_n = 1'b1;
    while (frames < 1) @(negedge clk);
    ready_pct = 50;
    while (frames < 2) @(negedge clk);
    // directed long stall mid-frame
    while (pos != 40) @(negedge clk);
    ready_pct = 0;
    repeat (30) @(negedge clk);
    ready_pct = 60;
    while (frames < 3) @(negedge clk);
    repeat (3) @(negedge clk);
    cont = 1'b0;
    while (frames < 4) @(negedge clk);
    repeat (40) begin
      @(negedge clk);
      chk(en == '0 && !tx_valid, "R9", 32'(en), 0);
    end
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    chk(en == 24'd1, "R9", 32'(en), 1);
    while (!en[5]) @(negedge clk);
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
    while (frames < 5) @(negedge clk);
    repeat (40) begin
      @(negedge clk);
      chk(en == '0 && !tx_valid, "R9", 32'(en), 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule